// File: doc/BRIEF.md
# Data-Processing Second Operand Shifter and Immediate Expander

This block builds the second operand of a data-processing instruction and the shifter carry-out that goes with it. One of four operand forms is chosen per request. There are two immediate forms. The wide immediate is an 8-bit constant rotated by an even amount. The narrow immediate is a 12-bit code that yields either a replicated byte pattern or a rotated constant with a leading one. The two register forms take a register value shifted by a 5-bit immediate amount, or by the low byte of a second register.

Every form is first turned into a single shift request: a value, a shift kind and an amount. That request then goes through one shared shifter, which produces the operand and the carry-out. The result is captured in a register one clock after a valid request. The flag for an unpredictable encoding is captured alongside it. The ALU and the register file sit outside this block.

Top module: `opnd_expander`

## Requirements
- R1: Form code 2'b10 (register, immediate amount) with shift type 2'b00 shifts the register left by the 5-bit amount, and the carry-out is the last bit shifted out. An amount of 0 passes the register through unchanged, with carry-out equal to carry-in.
- R2: In form 2'b10, type 2'b01 is a logical right shift and type 2'b10 is an arithmetic right shift, each by the 5-bit amount, where an amount of 0 stands for 32.
- R3: In form 2'b10, type 2'b11 with amount 0 is a one-bit rotate right through the carry: the carry-in enters bit 31 and bit 0 becomes the carry-out. A nonzero amount is a plain rotate right, and the carry-out is result bit 31.
- R4: Form code 2'b11 (register, register amount) maps type 00/01/10/11 to left, logical right, arithmetic right and rotate right. The amount is the full 8-bit shift byte, and an amount of 0 passes the value through with carry-out equal to carry-in.
- R5: A left or logical right shift by exactly 32 gives a zero result, with the carry-out equal to the last bit shifted out (bit 0 for left, bit 31 for right). A shift by more than 32 gives a zero result and a zero carry-out.
- R6: An arithmetic right shift by 32 or more fills every bit with bit 31 of the input, and the carry-out equals that bit.
- R7: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged and makes the carry-out equal to bit 31.
- R8: Form code 2'b00 (wide immediate) zero-extends imm12[7:0] and rotates it right by twice imm12[11:8]. With a rotation of 0 the carry-out equals the carry-in; otherwise it is result bit 31.
- R9: Form code 2'b01 (narrow immediate) with imm12[11:10] = 00 selects by imm12[9:8]: 00 gives the byte zero-extended, 01 gives 0x00BB00BB, 10 gives 0xBB00BB00 and 11 gives 0xBBBBBBBB, where BB is imm12[7:0]. The carry-out equals the carry-in.
- R10: The unpredictable flag is set only for form 2'b01 with imm12[11:10] = 00, imm12[9:8] nonzero and imm12[7:0] = 0. Every other request clears it.
- R11: Form 2'b01 with imm12[11:10] nonzero yields the 8-bit value {1, imm12[6:0]}, zero-extended and rotated right by imm12[11:7]. The carry-out is result bit 31.
- R12: Results appear one clock after a request with in_valid high, and out_valid is high in that cycle only. Without a request the result outputs hold their values. A synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_form | input | 2 | Operand form: 00 wide imm, 01 narrow imm, 10 register by imm, 11 register by register |
| in_imm12 | input | 12 | 12-bit immediate field for forms 00 and 01 |
| in_sh_type | input | 2 | Shift type for forms 10 and 11 |
| in_sh_imm5 | input | 5 | Immediate shift amount for form 10 |
| in_rm | input | 32 | Register value to be shifted |
| in_rs_lo | input | 8 | Low byte of the shift-amount register for form 11 |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_operand | output | 32 | Second operand |
| out_carry | output | 1 | Shifter carry-out |
| out_unpred | output | 1 | Unpredictable-encoding flag |

## Verification
Operand, carry-out and unpredictable flag are all due exactly one rising edge after the request that carries in_valid. No result appears earlier, and none lingers beyond that cycle as a valid strobe. The bench drives each request on a falling edge and reads all three results on the next falling edge, half a period after the capture edge. A new request is presented in the same step, so the table runs back to back. The directed tests then drop in_valid and confirm, one falling edge later, that the strobe is low while the last result is still held.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int OPW   = 32;
    localparam int IMMW  = 12;
    localparam int BYTEW = 8;
    localparam int AMTW  = 8;
    localparam int SH5W  = 5;
    localparam int ROTW  = $clog2(OPW);

    typedef enum logic [1:0] {
        FORM_WIDE_IMM   = 2'b00,
        FORM_NARROW_IMM = 2'b01,
        FORM_REG_IMM    = 2'b10,
        FORM_REG_REG    = 2'b11
    } form_e;

    typedef enum logic [2:0] {
        SK_LSL,
        SK_LSR,
        SK_ASR,
        SK_ROR,
        SK_RRX
    } shift_kind_e;

    typedef struct packed {
        logic [OPW-1:0]  value;
        shift_kind_e     kind;
        logic [AMTW-1:0] amount;
    } shift_req_t;

    typedef struct packed {
        logic [OPW-1:0] value;
        logic           carry;
    } shift_res_t;

    function automatic shift_kind_e kind_of_type(input logic [1:0] t);
        case (t)
            2'b00:   return SK_LSL;
            2'b01:   return SK_LSR;
            2'b10:   return SK_ASR;
            default: return SK_ROR;
        endcase
    endfunction

endpackage

// File: rtl/opnd_narrow_imm.sv
module opnd_narrow_imm
    import opnd_pkg::*;
(
    input  logic [IMMW-1:0] imm12,
    output shift_req_t      req,
    output logic            unpred
);
    localparam int REPS = OPW / (2 * BYTEW);

    logic [BYTEW-1:0] byte_v;
    logic [1:0]       pick;

    assign byte_v = imm12[BYTEW-1:0];
    assign pick   = imm12[9:8];

    always_comb begin
        req    = '0;
        unpred = 1'b0;
        if (imm12[11:10] == 2'b00) begin
            // replicated pattern: amount 0 lets the carry pass through
            req.kind   = SK_LSL;
            req.amount = '0;
            case (pick)
                2'b00:   req.value = OPW'(byte_v);
                2'b01:   req.value = {REPS{{BYTEW{1'b0}}, byte_v}};
                2'b10:   req.value = {REPS{byte_v, {BYTEW{1'b0}}}};
                default: req.value = {(2*REPS){byte_v}};
            endcase
            unpred = (pick != 2'b00) && (byte_v == '0);
        end else begin
            req.kind   = SK_ROR;
            req.value  = OPW'({1'b1, imm12[6:0]});
            req.amount = AMTW'(imm12[11:7]);
        end
    end
endmodule

// File: rtl/opnd_decode.sv
module opnd_decode
    import opnd_pkg::*;
(
    input  form_e            form,
    input  logic [IMMW-1:0]  imm12,
    input  logic [1:0]       sh_type,
    input  logic [SH5W-1:0]  sh_imm5,
    input  logic [OPW-1:0]   rm,
    input  logic [AMTW-1:0]  rs_lo,
    input  shift_req_t       narrow_req,
    output shift_req_t       req
);
    localparam logic [AMTW-1:0] FULL_AMT = AMTW'(OPW);

    always_comb begin
        req = '0;
        case (form)
            FORM_WIDE_IMM: begin
                req.value  = OPW'(imm12[BYTEW-1:0]);
                req.kind   = SK_ROR;
                req.amount = AMTW'({imm12[11:8], 1'b0});
            end
            FORM_NARROW_IMM: begin
                req = narrow_req;
            end
            FORM_REG_IMM: begin
                req.value = rm;
                case (sh_type)
                    2'b00: begin
                        req.kind   = SK_LSL;
                        req.amount = AMTW'(sh_imm5);
                    end
                    2'b01, 2'b10: begin
                        req.kind   = kind_of_type(sh_type);
                        req.amount = (sh_imm5 == '0) ? FULL_AMT : AMTW'(sh_imm5);
                    end
                    default: begin
                        if (sh_imm5 == '0) begin
                            req.kind   = SK_RRX;
                            req.amount = AMTW'(1);
                        end else begin
                            req.kind   = SK_ROR;
                            req.amount = AMTW'(sh_imm5);
                        end
                    end
                endcase
            end
            default: begin
                req.value  = rm;
                req.kind   = kind_of_type(sh_type);
                req.amount = rs_lo;
            end
        endcase
    end
endmodule

// File: rtl/opnd_barrel.sv
module opnd_barrel
    import opnd_pkg::*;
(
    input  shift_req_t req,
    input  logic       carry_in,
    output shift_res_t res
);
    localparam logic [AMTW-1:0] FULL_AMT = AMTW'(OPW);

    logic [OPW:0]       wide;
    logic [AMTW-1:0]    amt_c;
    logic [ROTW-1:0]    rot;
    logic [OPW-1:0]     rotated;

    always_comb begin
        wide    = '0;
        amt_c   = (req.amount > FULL_AMT) ? FULL_AMT : req.amount;
        rot     = req.amount[ROTW-1:0];
        rotated = (req.value >> rot) | (req.value << (OPW - int'(rot)));
        res     = '0;
        if (req.amount == '0) begin
            res.value = req.value;
            res.carry = carry_in;
        end else begin
            case (req.kind)
                SK_LSL: begin
                    if (req.amount <= FULL_AMT) begin
                        wide      = {1'b0, req.value} << req.amount;
                        res.value = wide[OPW-1:0];
                        res.carry = wide[OPW];
                    end
                end
                SK_LSR: begin
                    if (req.amount <= FULL_AMT) begin
                        wide      = {req.value, 1'b0} >> req.amount;
                        res.value = wide[OPW:1];
                        res.carry = wide[0];
                    end
                end
                SK_ASR: begin
                    wide      = (OPW+1)'($signed({req.value, 1'b0}) >>> amt_c);
                    res.value = wide[OPW:1];
                    res.carry = wide[0];
                end
                SK_ROR: begin
                    res.value = rotated;
                    res.carry = rotated[OPW-1];
                end
                default: begin
                    res.value = {carry_in, req.value[OPW-1:1]};
                    res.carry = req.value[0];
                end
            endcase
        end
    end
endmodule

// File: rtl/opnd_expander.sv
module opnd_expander
    import opnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_form,
    input  logic [IMMW-1:0]  in_imm12,
    input  logic [1:0]       in_sh_type,
    input  logic [SH5W-1:0]  in_sh_imm5,
    input  logic [OPW-1:0]   in_rm,
    input  logic [AMTW-1:0]  in_rs_lo,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [OPW-1:0]   out_operand,
    output logic             out_carry,
    output logic             out_unpred
);
    form_e      form;
    shift_req_t narrow_req;
    shift_req_t req;
    shift_res_t res;
    logic       narrow_unpred;

    assign form = form_e'(in_form);

    opnd_narrow_imm u_narrow (
        .imm12  (in_imm12),
        .req    (narrow_req),
        .unpred (narrow_unpred)
    );

    opnd_decode u_decode (
        .form       (form),
        .imm12      (in_imm12),
        .sh_type    (in_sh_type),
        .sh_imm5    (in_sh_imm5),
        .rm         (in_rm),
        .rs_lo      (in_rs_lo),
        .narrow_req (narrow_req),
        .req        (req)
    );

    opnd_barrel u_barrel (
        .req      (req),
        .carry_in (in_carry),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_operand <= '0;
            out_carry   <= 1'b0;
            out_unpred  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_operand <= res.value;
                out_carry   <= res.carry;
                out_unpred  <= (form == FORM_NARROW_IMM) && narrow_unpred;
            end
        end
    end

    assert_valid_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_operand) && $stable(out_carry)));

    assert_zero_amount_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_form == 2'b10 && in_sh_type == 2'b00 && in_sh_imm5 == '0)
        |=> (out_operand == $past(in_rm) && out_carry == $past(in_carry)));

    assert_logical_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_form == 2'b11 && !in_sh_type[1] && in_rs_lo > AMTW'(OPW))
        |=> (out_operand == '0 && !out_carry));

    assert_asr_sign_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_form == 2'b11 && in_sh_type == 2'b10 && in_rs_lo >= AMTW'(OPW))
        |=> (out_operand == {OPW{$past(in_rm[OPW-1])}} && out_carry == $past(in_rm[OPW-1])));

    assert_ror_multiple_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_form == 2'b11 && in_sh_type == 2'b11 &&
         in_rs_lo != '0 && in_rs_lo[ROTW-1:0] == '0)
        |=> (out_operand == $past(in_rm) && out_carry == $past(in_rm[OPW-1])));

    assert_unpred_scope_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_form != 2'b01) |=> !out_unpred);

endmodule

// File: tb/opnd_expander_bench.sv
`timescale 1ns/1ps
module opnd_expander_bench;

    typedef struct packed {
        logic [1:0]  form;
        logic [11:0] imm;
        logic [1:0]  typ;
        logic [4:0]  amt5;
        logic [31:0] rm;
        logic [7:0]  rs;
        logic        cin;
        logic [31:0] exp_v;
        logic        exp_c;
        logic        exp_u;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        // R1 register by immediate, left
        '{2'd2, 12'h000, 2'd0, 5'd4,  32'h80000001, 8'h00, 1'b0, 32'h00000010, 1'b0, 1'b0, 4'd1},
        '{2'd2, 12'h000, 2'd0, 5'd0,  32'h80000001, 8'h00, 1'b1, 32'h80000001, 1'b1, 1'b0, 4'd1},
        '{2'd2, 12'h000, 2'd0, 5'd31, 32'h00000003, 8'h00, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd1},
        // R2 right shifts, zero amount means 32
        '{2'd2, 12'h000, 2'd1, 5'd0,  32'h80000001, 8'h00, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd2},
        '{2'd2, 12'h000, 2'd1, 5'd1,  32'h80000001, 8'h00, 1'b0, 32'h40000000, 1'b1, 1'b0, 4'd2},
        '{2'd2, 12'h000, 2'd2, 5'd0,  32'h80000001, 8'h00, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd2},
        '{2'd2, 12'h000, 2'd2, 5'd4,  32'h80000010, 8'h00, 1'b1, 32'hF8000001, 1'b0, 1'b0, 4'd2},
        // R3 rotate through carry and plain rotate
        '{2'd2, 12'h000, 2'd3, 5'd0,  32'h80000001, 8'h00, 1'b0, 32'h40000000, 1'b1, 1'b0, 4'd3},
        '{2'd2, 12'h000, 2'd3, 5'd0,  32'h00000002, 8'h00, 1'b1, 32'h80000001, 1'b0, 1'b0, 4'd3},
        '{2'd2, 12'h000, 2'd3, 5'd1,  32'h80000001, 8'h00, 1'b0, 32'hC0000000, 1'b1, 1'b0, 4'd3},
        // R4 register by register
        '{2'd3, 12'h000, 2'd0, 5'd0,  32'h80000001, 8'h00, 1'b1, 32'h80000001, 1'b1, 1'b0, 4'd4},
        '{2'd3, 12'h000, 2'd1, 5'd0,  32'h80000001, 8'h08, 1'b0, 32'h00800000, 1'b0, 1'b0, 4'd4},
        '{2'd3, 12'h000, 2'd2, 5'd0,  32'h80000010, 8'h04, 1'b0, 32'hF8000001, 1'b0, 1'b0, 4'd4},
        '{2'd3, 12'h000, 2'd3, 5'd0,  32'h80000001, 8'h01, 1'b0, 32'hC0000000, 1'b1, 1'b0, 4'd4},
        // R5 logical by 32 and beyond
        '{2'd3, 12'h000, 2'd0, 5'd0,  32'h80000001, 8'h20, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd5},
        '{2'd3, 12'h000, 2'd0, 5'd0,  32'h80000001, 8'h21, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd5},
        '{2'd3, 12'h000, 2'd1, 5'd0,  32'h80000001, 8'h20, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd5},
        '{2'd3, 12'h000, 2'd1, 5'd0,  32'h80000001, 8'hFF, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd5},
        // R6 arithmetic by 32 and beyond
        '{2'd3, 12'h000, 2'd2, 5'd0,  32'h80000001, 8'h28, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
        '{2'd3, 12'h000, 2'd2, 5'd0,  32'h7FFFFFFF, 8'hC8, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd6},
        '{2'd3, 12'h000, 2'd2, 5'd0,  32'h80000001, 8'h20, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
        // R7 rotate modulo 32
        '{2'd3, 12'h000, 2'd3, 5'd0,  32'h80000001, 8'h40, 1'b0, 32'h80000001, 1'b1, 1'b0, 4'd7},
        '{2'd3, 12'h000, 2'd3, 5'd0,  32'h80000001, 8'h24, 1'b1, 32'h18000000, 1'b0, 1'b0, 4'd7},
        '{2'd3, 12'h000, 2'd3, 5'd0,  32'h70000000, 8'h20, 1'b1, 32'h70000000, 1'b0, 1'b0, 4'd7},
        // R8 wide immediate
        '{2'd0, 12'h0FF, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b1, 32'h000000FF, 1'b1, 1'b0, 4'd8},
        '{2'd0, 12'h4FF, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b0, 32'hFF000000, 1'b1, 1'b0, 4'd8},
        '{2'd0, 12'h102, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd8},
        '{2'd0, 12'hF01, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b1, 32'h00000004, 1'b0, 1'b0, 4'd8},
        // R9 narrow immediate replicated patterns
        '{2'd1, 12'h0AB, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b1, 32'h000000AB, 1'b1, 1'b0, 4'd9},
        '{2'd1, 12'h1AB, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b1, 32'h00AB00AB, 1'b1, 1'b0, 4'd9},
        '{2'd1, 12'h2AB, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b0, 32'hAB00AB00, 1'b0, 1'b0, 4'd9},
        '{2'd1, 12'h3AB, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b0, 32'hABABABAB, 1'b0, 1'b0, 4'd9},
        // R10 unpredictable zero byte
        '{2'd1, 12'h100, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b1, 32'h00000000, 1'b1, 1'b1, 4'd10},
        '{2'd1, 12'h300, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd10},
        // R11 narrow immediate rotated constant (last entry, used by hold test)
        '{2'd1, 12'h47F, 2'd0, 5'd0,  32'h00000000, 8'h00, 1'b0, 32'hFF000000, 1'b1, 1'b0, 4'd11}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_form;
    logic [11:0] in_imm12;
    logic [1:0]  in_sh_type;
    logic [4:0]  in_sh_imm5;
    logic [31:0] in_rm;
    logic [7:0]  in_rs_lo;
    logic        in_carry;
    logic        out_valid;
    logic [31:0] out_operand;
    logic        out_carry;
    logic        out_unpred;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    opnd_expander u_opnd_expander (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_form     (in_form),
        .in_imm12    (in_imm12),
        .in_sh_type  (in_sh_type),
        .in_sh_imm5  (in_sh_imm5),
        .in_rm       (in_rm),
        .in_rs_lo    (in_rs_lo),
        .in_carry    (in_carry),
        .out_valid   (out_valid),
        .out_operand (out_operand),
        .out_carry   (out_carry),
        .out_unpred  (out_unpred)
    );

    task automatic drive(input logic [1:0] f, input logic [11:0] imm, input logic [1:0] t,
                         input logic [4:0] a5, input logic [31:0] rm, input logic [7:0] rs,
                         input logic c, input logic v);
        in_form    = f;
        in_imm12   = imm;
        in_sh_type = t;
        in_sh_imm5 = a5;
        in_rm      = rm;
        in_rs_lo   = rs;
        in_carry   = c;
        in_valid   = v;
    endtask

    task automatic check(input string tag, input logic v, input logic [31:0] op,
                         input logic c, input logic u);
        total++;
        if (out_valid !== v || out_operand !== op || out_carry !== c || out_unpred !== u) begin
            bad++;
            $display("FAIL %s: got v=%b op=%h c=%b u=%b, expected v=%b op=%h c=%b u=%b",
                     tag, out_valid, out_operand, out_carry, out_unpred, v, op, c, u);
        end
    endtask

    initial begin
        rst = 1'b1;
        drive(2'd0, 12'h000, 2'd0, 5'd0, 32'h0, 8'h0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R12 reset state", 1'b0, 32'h0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 idle after reset", 1'b0, 32'h0, 1'b0, 1'b0);

        // back-to-back table walk: drive on a falling edge, read one clock later
        drive(VECS[0].form, VECS[0].imm, VECS[0].typ, VECS[0].amt5,
              VECS[0].rm, VECS[0].rs, VECS[0].cin, 1'b1);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), 1'b1,
                  VECS[i].exp_v, VECS[i].exp_c, VECS[i].exp_u);
            if (i + 1 < NV)
                drive(VECS[i+1].form, VECS[i+1].imm, VECS[i+1].typ, VECS[i+1].amt5,
                      VECS[i+1].rm, VECS[i+1].rs, VECS[i+1].cin, 1'b1);
            else
                drive(2'd1, 12'h300, 2'd0, 5'd0, 32'h12345678, 8'h00, 1'b0, 1'b0);
        end

        // R12: no request, outputs hold the last result
        @(negedge clk);
        check("R12 hold without request", 1'b0, 32'hFF000000, 1'b1, 1'b0);

        // R10: flag clears for a zero byte with selector 00
        drive(2'd1, 12'h000, 2'd0, 5'd0, 32'h0, 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        check("R10 zero byte selector 00", 1'b1, 32'h00000000, 1'b1, 1'b0);

        // R10: unpredictable set, then a register form clears it
        drive(2'd1, 12'h200, 2'd0, 5'd0, 32'h0, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 selector 10 zero byte", 1'b1, 32'h00000000, 1'b0, 1'b1);
        drive(2'd2, 12'h100, 2'd0, 5'd0, 32'h00000005, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 cleared by register form", 1'b1, 32'h00000005, 1'b0, 1'b0);

        // R11: largest rotation
        drive(2'd1, 12'hFFF, 2'd0, 5'd0, 32'h0, 8'h00, 1'b1, 1'b1);
        @(negedge clk);
        check("R11 rotate by 31", 1'b1, 32'h000001FE, 1'b0, 1'b0);

        // R12: reset in mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check("R12 reset mid-run", 1'b0, 32'h0, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule